// File: doc/BRIEF.md
# Ripple-Carry Arithmetic Logic Unit with Subtraction

This block is a parameterised N-bit arithmetic logic unit (32 bits by default). It is built as a row of identical one-bit slices. Each slice holds a bitwise AND, a bitwise OR and a full adder, and an output selector picks one of the three. The carry runs serially from the lowest slice to the highest. The block offers AND, OR, addition and subtraction.

Subtraction uses the same adders as addition. A single invert control complements the second operand before it reaches any slice, and the same control drives the carry into bit 0. The adder chain therefore forms `a + ~b + 1`, and no separate subtractor exists.

The row of slices is combinational. The word result and the carry leaving the top slice are captured in an output register on each rising clock edge. A synchronous active-high reset clears that register.

Top module: `rc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `result` and `carry_out` are 0 after that edge.
- R2: With `op_sel` = 2'b00, `result` becomes `opnd_a & b_eff`. Here `b_eff` is `~opnd_b` when `b_inv` is 1 and `opnd_b` when it is 0.
- R3: With `op_sel` = 2'b01, `result` becomes `opnd_a | b_eff`.
- R4: With `op_sel` = 2'b10 and `b_inv` = 0, `result` becomes the low N bits of `opnd_a + opnd_b`, with a carry-in of 0 at bit 0.
- R5: With `op_sel` = 2'b10 and `b_inv` = 1, `result` becomes the low N bits of `opnd_a + ~opnd_b + 1`, which is `opnd_a - opnd_b` modulo 2^N.
- R6: With `op_sel` = 2'b11, `result` becomes all zeros.
- R7: For every `op_sel` value, `carry_out` becomes bit N of the (N+1)-bit sum `opnd_a + b_eff + b_inv`. In subtraction this means `carry_out` is 1 exactly when `opnd_a >= opnd_b` (unsigned).
- R8: The outputs change only at a rising clock edge. They reflect the inputs that were present at that edge, so the latency is one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the output register |
| opnd_a | input | W | First operand |
| opnd_b | input | W | Second operand |
| op_sel | input | 2 | Operation: 00 AND, 01 OR, 10 add/subtract, 11 zero |
| b_inv | input | 1 | Complement the second operand and set the bit-0 carry-in |
| result | output | W | Registered word result |
| carry_out | output | 1 | Registered carry out of the top slice |

## Verification
Every result and carry is due exactly one rising edge after its operands and controls are applied. The bench changes the inputs on a falling edge and compares the outputs on the next falling edge, which lies half a period after the capturing edge. Just before that capturing edge, the bench confirms that the outputs still hold the previous operation's value, which checks the one-cycle latency. The checker relates each registered output to the inputs it saw one edge earlier.

// File: rtl/rc_alu_pkg.sv
package rc_alu_pkg;
  typedef enum logic [1:0] {
    OP_AND   = 2'b00,
    OP_OR    = 2'b01,
    OP_ARITH = 2'b10,
    OP_NONE  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/rc_alu_slice.sv
module rc_alu_slice
  import rc_alu_pkg::*;
(
  input  logic    a,
  input  logic    b,
  input  logic    b_inv,
  input  logic    cin,
  input  alu_op_e op,
  output logic    res,
  output logic    cout
);
  logic b_eff;
  logic half;
  logic sum;

  assign b_eff = b ^ b_inv;
  assign half  = a ^ b_eff;
  assign sum   = half ^ cin;
  assign cout  = (a & b_eff) | (cin & half);

  always_comb begin
    unique case (op)
      OP_AND:   res = a & b_eff;
      OP_OR:    res = a | b_eff;
      OP_ARITH: res = sum;
      default:  res = 1'b0;
    endcase
  end
endmodule

// File: rtl/rc_alu_chain.sv
module rc_alu_chain
  import rc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         b_inv,
  input  alu_op_e      op,
  output logic [W-1:0] res,
  output logic         cout
);
  logic [W:0] carry;

  // Subtract injects the +1 of the two's complement at bit 0.
  assign carry[0] = b_inv;

  for (genvar i = 0; i < W; i++) begin : g_slice
    rc_alu_slice u_slice (
      .a     (a[i]),
      .b     (b[i]),
      .b_inv (b_inv),
      .cin   (carry[i]),
      .op    (op),
      .res   (res[i]),
      .cout  (carry[i+1])
    );
  end

  assign cout = carry[W];
endmodule

// File: rtl/rc_alu_outreg.sv
module rc_alu_outreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_res,
  input  logic         d_cout,
  output logic [W-1:0] q_res,
  output logic         q_cout
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_res  <= '0;
      q_cout <= 1'b0;
    end else begin
      q_res  <= d_res;
      q_cout <= d_cout;
    end
  end
endmodule

// File: rtl/rc_alu.sv
module rc_alu
  import rc_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic [1:0]   op_sel,
  input  logic         b_inv,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic [W-1:0] comb_res;
  logic         comb_cout;

  rc_alu_chain #(.W(W)) u_chain (
    .a     (opnd_a),
    .b     (opnd_b),
    .b_inv (b_inv),
    .op    (alu_op_e'(op_sel)),
    .res   (comb_res),
    .cout  (comb_cout)
  );

  rc_alu_outreg #(.W(W)) u_outreg (
    .clk    (clk),
    .rst    (rst),
    .d_res  (comb_res),
    .d_cout (comb_cout),
    .q_res  (result),
    .q_cout (carry_out)
  );
endmodule

// File: rtl/rc_alu_chk.sv
module rc_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic [1:0]   op_sel,
  input logic         b_inv,
  input logic [W-1:0] result,
  input logic         carry_out
);
  logic         rst_q;
  logic [W-1:0] be;
  logic [W:0]   wide;

  always_ff @(posedge clk) rst_q <= rst;

  assign be   = b_inv ? ~opnd_b : opnd_b;
  assign wide = {1'b0, opnd_a} + {1'b0, be} + {{W{1'b0}}, b_inv};

  always @(negedge clk) begin
    if (rst_q) begin
      AST_RESET_CLEARS: assert (result == '0 && carry_out == 1'b0); // R1
    end
  end

  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b00) |-> result == ($past(opnd_a) & $past(be))); // R2

  AST_OR_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b01) |-> result == ($past(opnd_a) | $past(be))); // R3

  AST_ARITH_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b10) |-> result == $past(wide[W-1:0])); // R5

  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(op_sel) == 2'b11) |-> result == '0); // R6

  AST_CARRY_OUT: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> carry_out == $past(wide[W])); // R7
endmodule

bind rc_alu rc_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .opnd_a    (opnd_a),
  .opnd_b    (opnd_b),
  .op_sel    (op_sel),
  .b_inv     (b_inv),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/rc_alu_tb.sv
module rc_alu_tb;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = '1;
  localparam logic [W-1:0] MSB  = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] opnd_a = '0;
  logic [W-1:0] opnd_b = '0;
  logic [1:0]   op_sel = 2'b00;
  logic         b_inv = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rc_alu #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .opnd_a(opnd_a), .opnd_b(opnd_b),
    .op_sel(op_sel), .b_inv(b_inv), .result(result), .carry_out(carry_out)
  );

  function automatic logic [W:0] model(logic [W-1:0] a, logic [W-1:0] b,
                                       logic [1:0] op, logic inv);
    logic [W-1:0] be;
    logic [W:0]   s;
    logic [W-1:0] r;
    be = inv ? ~b : b;
    s  = {1'b0, a} + {1'b0, be} + {{W{1'b0}}, inv};
    case (op)
      2'b00:   r = a & be;
      2'b01:   r = a | be;
      2'b10:   r = s[W-1:0];
      default: r = '0;
    endcase
    return {s[W], r};
  endfunction

  task automatic check(string req, logic [W:0] act, logic [W:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual carry/result %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, compare half a period after the capturing edge.
  task automatic run(string req, logic [W-1:0] a, logic [W-1:0] b,
                     logic [1:0] op, logic inv);
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = op; b_inv = inv;
    @(negedge clk);
    check(req, {carry_out, result}, model(a, b, op, inv));
  endtask

  task automatic t_reset();
    rst = 1'b1;
    opnd_a = ONES; opnd_b = ONES; op_sel = 2'b01; b_inv = 1'b0;
    repeat (2) @(negedge clk);
    check("R1", {carry_out, result}, '0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_and();
    run("R2", 32'hF0F0_1234, 32'hFF00_FF0F, 2'b00, 1'b0);
    run("R2", 32'hF0F0_1234, 32'hFF00_FF0F, 2'b00, 1'b1);
    run("R2", ONES, MSB, 2'b00, 1'b0);
  endtask

  task automatic t_or();
    run("R3", 32'h0000_1234, 32'h8000_0001, 2'b01, 1'b0);
    run("R3", '0, ONES, 2'b01, 1'b1);
    run("R3", MSB, '0, 2'b01, 1'b0);
  endtask

  task automatic t_add();
    run("R4", 32'd7, 32'd9, 2'b10, 1'b0);
    run("R4 R7 wrap", ONES, 32'd1, 2'b10, 1'b0);
    run("R4 R7 msb", MSB, MSB, 2'b10, 1'b0);
    run("R4 zero", '0, '0, 2'b10, 1'b0);
  endtask

  task automatic t_sub();
    run("R5 7-6", 32'd7, 32'd6, 2'b10, 1'b1);
    run("R5 R7 borrow", 32'd6, 32'd7, 2'b10, 1'b1);
    run("R5 R7 equal", ONES, ONES, 2'b10, 1'b1);
    run("R5 0-0", '0, '0, 2'b10, 1'b1);
    run("R5 0-msb", '0, MSB, 2'b10, 1'b1);
  endtask

  task automatic t_none();
    run("R6 R7", ONES, ONES, 2'b11, 1'b0);
    run("R6 R7", 32'd5, 32'd3, 2'b11, 1'b1);
  endtask

  task automatic t_latency();
    run("R8 prior", 32'd1, 32'd2, 2'b10, 1'b0);
    @(negedge clk);
    opnd_a = 32'h100; opnd_b = 32'h200; op_sel = 2'b10; b_inv = 1'b0;
    #8;
    check("R8 held before edge", {carry_out, result}, model(32'd1, 32'd2, 2'b10, 1'b0));
    @(negedge clk);
    check("R8 after edge", {carry_out, result}, model(32'h100, 32'h200, 2'b10, 1'b0));
  endtask

  task automatic t_random();
    for (int i = 0; i < 200; i++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 3));
      run("R2 R3 R4 R5 R6 R7 random", $urandom, $urandom, op, 1'($urandom_range(0, 1)));
    end
  endtask

  initial begin
    t_reset();
    t_and();
    t_or();
    t_add();
    t_sub();
    t_none();
    t_latency();
    t_random();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule